// File: doc/BRIEF.md
# Interleaved Two-Bank SECDED Word Store

This block is a protected word memory for a processor's local storage. Each 32-bit word is written with a 39-bit single-error-correcting, double-error-detecting code, and the code word is split between two physical arrays. Even code-word bits go to bank A and odd bits to bank B. Inside each bank, two logical words share one physical row and their bits alternate column by column. A burst that upsets neighbouring cells therefore hits different words, one bit each. Both banks scramble their row address with a different constant. If one bank decodes the wrong row, the rebuilt code word mixes halves of two words, and the decoder sees that mix as an error.

A read is accepted when the read enable is high and the write enable is low. Corrected data, a single-error flag and a double-error flag appear one clock later, together with a valid strobe. Two configuration inputs select how each error class is handled: ignored (flag only) or escalated on an abort output.

Test-only inputs do two things. One toggles a chosen physical cell. The other forces bank A to read the neighbouring physical row.

The control is a two-state machine:
- ST_IDLE: no result is presented. It moves to ST_SHOW when a read is accepted.
- ST_SHOW: the read result is presented. It stays in ST_SHOW on a further accepted read and returns to ST_IDLE otherwise.

The interleave and the bank split are fixed wiring, and no input disables them.

Top module: `ilv_ecc_mem`

## Requirements
- R1: A word written at an address is returned unchanged by a later read of that address. rd_valid is high in the cycle after the accepted read, with both error flags low.
- R2: After reset, and in any cycle not preceded by an accepted read, rd_valid, err_single, err_double and abort are all low and rd_data is zero.
- R3: Code-word layout:
  - Hamming positions 1..38 hold check bits at the power-of-two positions 1, 2, 4, 8, 16 and 32.
  - The data bits fill the remaining positions in ascending order, data bit 0 at position 3.
  - Bit 0 is the parity of positions 1..38.
  - Code-word bit 2k lives in bank A and bit 2k+1 in bank B, at column 2k+s of the row, where s is address bit 0 and the row is the remaining address bits.
- R4: A single toggled cell in either bank is corrected on read: rd_data equals the written word and err_single is high.
- R5: Two toggled cells of the same word give err_double high and err_single low, and rd_data is returned without correction.
- R6: Two adjacent toggled columns of one bank row are reported as one single-bit error in each of the two words sharing that row, and both words are corrected.
- R7: abort is high with a result only if that result's error class was selected for abort at the time of the read (resp_sb_abort for single, resp_db_abort for double).
- R8: When wr_en is high, rd_en and flt_tog are ignored in that cycle: no result follows and no cell is toggled.
- R9: A read with flt_dec high makes bank A read its neighbouring physical row. For word 4 holding 0 and word 6 holding 1, reading word 4 this way reports err_double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request (has priority) |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Word address |
| wr_data | input | 32 | Write data |
| resp_sb_abort | input | 1 | 1: single errors raise abort |
| resp_db_abort | input | 1 | 1: double errors raise abort |
| flt_tog | input | 1 | Test: toggle one stored cell |
| flt_bank | input | 1 | Test: bank of the toggled cell (0 = A) |
| flt_col | input | 6 | Test: physical column of the toggled cell |
| flt_dec | input | 1 | Test: bank A reads the neighbouring row |
| rd_data | output | 32 | Corrected read data |
| rd_valid | output | 1 | Read result present |
| err_single | output | 1 | Corrected single-bit error |
| err_double | output | 1 | Uncorrectable error |
| abort | output | 1 | Error escalated per configuration |

## Verification
The assertions assume that the response inputs are stable only in the cycle a read is accepted. They also assume that every address read has been written since reset, so no unknown cell values reach the decoder. The bench writes each word before reading it, drives all inputs on the falling edge, and rewrites every word it damaged before the next scenario. Each fault scenario uses column numbers that the layout requirement fixes, so the expected flags follow from that layout alone.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int DATA_W = 32;
    localparam int CODE_W = 39;
    localparam int SYN_W  = 6;
    localparam int A_BITS = (CODE_W + 1) / 2;
    localparam int B_BITS = CODE_W / 2;

    typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_SHOW = 1'b1} rd_state_e;

    function automatic logic is_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic logic [CODE_W-1:0] place_data(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] c;
        int k;
        c = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_pow2(p)) begin
                c[p] = d[k];
                k++;
            end
        end
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pick_data(input logic [CODE_W-1:0] c);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p < CODE_W; p++) begin
            if (!is_pow2(p)) begin
                d[k] = c[p];
                k++;
            end
        end
        return d;
    endfunction

    function automatic logic [SYN_W-1:0] syndrome(input logic [CODE_W-1:0] c);
        logic [SYN_W-1:0] s;
        s = '0;
        for (int p = 1; p < CODE_W; p++) begin
            if (c[p]) s = s ^ SYN_W'(p);
        end
        return s;
    endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import ilv_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] placed;
    logic [SYN_W-1:0]  chk;

    always_comb begin
        placed = place_data(data);
        chk    = syndrome(placed);
        code   = placed;
        for (int i = 0; i < SYN_W; i++) begin
            code[1 << i] = chk[i];
        end
        code[0] = ^code[CODE_W-1:1];
    end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import ilv_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] data,
    output logic              single,
    output logic              double
);
    logic [SYN_W-1:0]  syn;
    logic              par;
    logic [CODE_W-1:0] fixed;

    always_comb begin
        syn    = syndrome(code);
        par    = ^code;
        fixed  = code;
        single = 1'b0;
        double = 1'b0;
        if (par) begin
            if (int'(syn) < CODE_W) begin
                single = 1'b1;
                fixed[syn] = ~code[syn];
            end else begin
                double = 1'b1;
            end
        end else if (syn != '0) begin
            double = 1'b1;
        end
        data = pick_data(fixed);
    end
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int ROW_W = 5,
    parameter int BITS  = 20,
    parameter int SCR   = 0
) (
    input  logic             clk,
    input  logic             we,
    input  logic [ROW_W-1:0] wrow,
    input  logic             wslot,
    input  logic [BITS-1:0]  wbits,
    input  logic             tog,
    input  logic [ROW_W-1:0] trow,
    input  logic [5:0]       tcol,
    input  logic             re,
    input  logic             rflt,
    input  logic [ROW_W-1:0] rrow,
    output logic [2*BITS-1:0] rq
);
    localparam int ROWS = 1 << ROW_W;
    localparam int W    = 2 * BITS;
    localparam logic [ROW_W-1:0] SCR_V = ROW_W'(SCR);

    logic [W-1:0]     mem [ROWS];
    logic [ROW_W-1:0] pw, pt, pr;

    assign pw = wrow ^ SCR_V;
    assign pt = trow ^ SCR_V;
    assign pr = rrow ^ SCR_V ^ ROW_W'(rflt);

    always_ff @(posedge clk) begin
        if (we) begin
            for (int k = 0; k < BITS; k++) begin
                if (wslot) mem[pw][2*k+1] <= wbits[k];
                else       mem[pw][2*k]   <= wbits[k];
            end
        end else if (tog) begin
            for (int c = 0; c < W; c++) begin
                if (int'(tcol) == c) mem[pt][c] <= ~mem[pt][c];
            end
        end
        if (re) rq <= mem[pr];
    end
endmodule

// File: rtl/ilv_ecc_mem.sv
module ilv_ecc_mem
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SCR_A  = 5,
    parameter int SCR_B  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    input  logic              resp_sb_abort,
    input  logic              resp_db_abort,
    input  logic              flt_tog,
    input  logic              flt_bank,
    input  logic [5:0]        flt_col,
    input  logic              flt_dec,
    output logic [31:0]       rd_data,
    output logic              rd_valid,
    output logic              err_single,
    output logic              err_double,
    output logic              abort
);
    localparam int ROW_W = ADDR_W - 1;

    rd_state_e state_q, state_d;
    logic              rd_acc, tog_acc;
    logic [ROW_W-1:0]  row;
    logic              slot, slot_q, cfg_sb_q, cfg_db_q;
    logic [CODE_W-1:0] cw_w, cw_r;
    logic [A_BITS-1:0] a_w;
    logic [B_BITS-1:0] b_w;
    logic [2*A_BITS-1:0] a_q;
    logic [2*B_BITS-1:0] b_q;
    logic [DATA_W-1:0] dec_data;
    logic              dec_sb, dec_db;

    assign rd_acc  = rd_en & ~wr_en;
    assign tog_acc = flt_tog & ~wr_en;
    assign row     = addr[ADDR_W-1:1];
    assign slot    = addr[0];

    secded_enc u_enc (.data(wr_data), .code(cw_w));

    // Fixed split: even code bits to bank A, odd to bank B.
    for (genvar k = 0; k < A_BITS; k++) begin : g_split_a
        assign a_w[k]    = cw_w[2*k];
        assign cw_r[2*k] = slot_q ? a_q[2*k+1] : a_q[2*k];
    end
    for (genvar k = 0; k < B_BITS; k++) begin : g_split_b
        assign b_w[k]      = cw_w[2*k+1];
        assign cw_r[2*k+1] = slot_q ? b_q[2*k+1] : b_q[2*k];
    end

    ilv_bank #(.ROW_W(ROW_W), .BITS(A_BITS), .SCR(SCR_A)) u_bank_a (
        .clk(clk), .we(wr_en), .wrow(row), .wslot(slot), .wbits(a_w),
        .tog(tog_acc & ~flt_bank), .trow(row), .tcol(flt_col),
        .re(rd_acc), .rflt(flt_dec), .rrow(row), .rq(a_q)
    );

    ilv_bank #(.ROW_W(ROW_W), .BITS(B_BITS), .SCR(SCR_B)) u_bank_b (
        .clk(clk), .we(wr_en), .wrow(row), .wslot(slot), .wbits(b_w),
        .tog(tog_acc & flt_bank), .trow(row), .tcol(flt_col),
        .re(rd_acc), .rflt(1'b0), .rrow(row), .rq(b_q)
    );

    secded_dec u_dec (.code(cw_r), .data(dec_data), .single(dec_sb), .double(dec_db));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            slot_q   <= 1'b0;
            cfg_sb_q <= 1'b0;
            cfg_db_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rd_acc) begin
                slot_q   <= slot;
                cfg_sb_q <= resp_sb_abort;
                cfg_db_q <= resp_db_abort;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_acc)  state_d = ST_SHOW;
            ST_SHOW: if (!rd_acc) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_valid   = 1'b0;
        rd_data    = '0;
        err_single = 1'b0;
        err_double = 1'b0;
        abort      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SHOW: begin
                rd_valid   = 1'b1;
                rd_data    = dec_data;
                err_single = dec_sb;
                err_double = dec_db;
                abort      = (dec_sb & cfg_sb_q) | (dec_db & cfg_db_q);
            end
            default: ;
        endcase
    end

    // R1
    valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && !wr_en));
    // R2
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (!err_single && !err_double && !abort && rd_data == '0));
    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_single && err_double));
    // R7
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> ((err_single && $past(resp_sb_abort)) || (err_double && $past(resp_db_abort))));
    // R8
    write_blocks_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> !rd_valid);
endmodule

// File: tb/test_ilv_ecc_mem.sv
module test_ilv_ecc_mem;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 0, rd_en = 0;
    logic [5:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic        resp_sb_abort = 0, resp_db_abort = 0;
    logic        flt_tog = 0, flt_bank = 0, flt_dec = 0;
    logic [5:0]  flt_col = '0;
    logic [31:0] rd_data;
    logic        rd_valid, err_single, err_double, abort;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ilv_ecc_mem i_ilv_ecc_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .resp_sb_abort(resp_sb_abort), .resp_db_abort(resp_db_abort),
        .flt_tog(flt_tog), .flt_bank(flt_bank), .flt_col(flt_col), .flt_dec(flt_dec),
        .rd_data(rd_data), .rd_valid(rd_valid), .err_single(err_single),
        .err_double(err_double), .abort(abort)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic tog(input logic [5:0] a, input bit bank, input int col);
        @(negedge clk);
        flt_tog = 1; addr = a; flt_bank = bank; flt_col = 6'(col);
        @(negedge clk);
        flt_tog = 0;
    endtask

    // Read and compare: data, valid, single, double, abort
    task automatic rd_expect(input string req, input logic [5:0] a, input logic [31:0] d,
                             input bit sb, input bit db, input bit ab, input bit cmp_data);
        @(negedge clk);
        rd_en = 1; addr = a;
        @(negedge clk);
        rd_en = 0; flt_dec = 0;
        check(rd_valid == 1'b1, req, {31'b0, rd_valid}, 32'd1);
        if (cmp_data) check(rd_data == d, req, rd_data, d);
        check(err_single == sb, req, {31'b0, err_single}, {31'b0, sb});
        check(err_double == db, req, {31'b0, err_double}, {31'b0, db});
        check(abort == ab, req, {31'b0, abort}, {31'b0, ab});
    endtask

    task automatic t_reset;
        // R2
        check(!rd_valid && !err_single && !err_double && !abort && rd_data == 0,
              "R2 reset", {28'b0, rd_valid, err_single, err_double, abort}, 32'd0);
    endtask

    task automatic t_basic;
        // R1: several patterns at several addresses
        wr(6'd0, 32'h0000_0000);
        wr(6'd1, 32'hFFFF_FFFF);
        wr(6'd2, 32'hA5A5_5A5A);
        wr(6'd63, 32'h1234_5678);
        wr(6'd33, 32'h8000_0001);
        rd_expect("R1 a0", 6'd0, 32'h0000_0000, 0, 0, 0, 1);
        rd_expect("R1 a1", 6'd1, 32'hFFFF_FFFF, 0, 0, 0, 1);
        rd_expect("R1 a2", 6'd2, 32'hA5A5_5A5A, 0, 0, 0, 1);
        rd_expect("R1 a63", 6'd63, 32'h1234_5678, 0, 0, 0, 1);
        rd_expect("R1 a33", 6'd33, 32'h8000_0001, 0, 0, 0, 1);
        @(negedge clk);
        // R2: no read accepted in previous cycle
        check(!rd_valid && rd_data == 0, "R2 idle", rd_data, 32'd0);
    endtask

    task automatic t_single;
        // R4, R3: bank B col 7 of addr 3 (slot 1) = code bit 7
        wr(6'd3, 32'hDEAD_BEEF);
        tog(6'd3, 1'b1, 7);
        rd_expect("R4 bankB", 6'd3, 32'hDEAD_BEEF, 1, 0, 0, 1);
        wr(6'd3, 32'hDEAD_BEEF);
        // R4: bank A col 11 of addr 3 = code bit 10, abort selected for singles (R7)
        tog(6'd3, 1'b0, 11);
        resp_sb_abort = 1;
        rd_expect("R4 bankA R7", 6'd3, 32'hDEAD_BEEF, 1, 0, 1, 1);
        resp_sb_abort = 0;
        wr(6'd3, 32'hDEAD_BEEF);
        rd_expect("R4 restored", 6'd3, 32'hDEAD_BEEF, 0, 0, 0, 1);
    endtask

    task automatic t_adjacent;
        // R6: cols 20 and 21 of bank A row 5 belong to addr 10 and 11
        wr(6'd10, 32'h0F0F_0F0F);
        wr(6'd11, 32'h3C3C_C3C3);
        tog(6'd10, 1'b0, 20);
        tog(6'd10, 1'b0, 21);
        rd_expect("R6 w10", 6'd10, 32'h0F0F_0F0F, 1, 0, 0, 1);
        rd_expect("R6 w11", 6'd11, 32'h3C3C_C3C3, 1, 0, 0, 1);
        wr(6'd10, 32'h0F0F_0F0F);
        wr(6'd11, 32'h3C3C_C3C3);
    endtask

    task automatic t_double;
        // R5: cols 0 and 4 of bank A, addr 12 slot 0 = code bits 0 and 4 (no data bits)
        wr(6'd12, 32'hCAFE_F00D);
        tog(6'd12, 1'b0, 0);
        tog(6'd12, 1'b0, 4);
        rd_expect("R5 ignore", 6'd12, 32'hCAFE_F00D, 0, 1, 0, 1);
        resp_db_abort = 1;
        rd_expect("R7 abort", 6'd12, 32'hCAFE_F00D, 0, 1, 1, 1);
        resp_db_abort = 0;
        resp_sb_abort = 1;
        rd_expect("R7 wrong class", 6'd12, 32'hCAFE_F00D, 0, 1, 0, 1);
        resp_sb_abort = 0;
        wr(6'd12, 32'hCAFE_F00D);
    endtask

    task automatic t_decode;
        // R9
        wr(6'd4, 32'h0000_0000);
        wr(6'd6, 32'h0000_0001);
        @(negedge clk);
        flt_dec = 1;
        rd_expect("R9 decode", 6'd4, 32'h0, 0, 1, 0, 0);
        rd_expect("R9 clean", 6'd4, 32'h0, 0, 0, 0, 1);
    endtask

    task automatic t_priority;
        // R8: write and read together: no result, write lands
        wr(6'd20, 32'h1111_1111);
        @(negedge clk);
        wr_en = 1; rd_en = 1; addr = 6'd20; wr_data = 32'h2222_2222;
        @(negedge clk);
        wr_en = 0; rd_en = 0;
        check(!rd_valid, "R8 read ignored", {31'b0, rd_valid}, 32'd0);
        rd_expect("R8 write kept", 6'd20, 32'h2222_2222, 0, 0, 0, 1);
        // R8: toggle together with write is ignored
        @(negedge clk);
        wr_en = 1; flt_tog = 1; flt_bank = 0; flt_col = 6'd2; addr = 6'd20; wr_data = 32'h3333_3333;
        @(negedge clk);
        wr_en = 0; flt_tog = 0;
        rd_expect("R8 toggle ignored", 6'd20, 32'h3333_3333, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_basic();
        t_single();
        t_adjacent();
        t_double();
        t_decode();
        t_priority();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule